// File: doc/BRIEF.md
# Next Program Counter Selector

This block decides where a single-cycle processor fetches its next instruction, and it holds the program counter register that the decision feeds. In every cycle it forms the sequential address (current PC plus four) and a PC-relative branch target from a signed 16-bit word displacement. It also forms a direct jump target: the upper four bits of the sequential address, followed by a 26-bit word index and two zero bits. It then picks the sequential address, the branch target, the direct target or a register operand. The choice depends on a branch request, a zero flag from the comparison and a two-bit jump kind.

The sequential address also leaves the block as the link value for call-type jumps. Decode and the register file sit outside the block. The register is written only on the rising clock edge, so the sequential address, the link value and the selected next address stay stable for the whole cycle. A synchronous reset returns the counter to address zero.

The block has no state machine. The only state is the PC register. The selection is a combinational priority: a register jump or a direct jump comes first, then a taken branch, then sequential flow.

Top module: `pc_sequencer`

## Requirements
- R1: With jump kind 2'b00 and no taken branch, `next_pc_o` equals `pc_o + 4` (modulo 2^32).
- R2: With jump kind 2'b00, `branch_i` high and `zero_i` high, `next_pc_o` equals `pc_o + 4 + (sign-extended imm_i << 2)`. Bit 15 of `imm_i` is the sign, and the sum wraps modulo 2^32.
- R3: When `branch_i` is high and `zero_i` is low with no jump, the branch is not taken and `next_pc_o` equals `pc_o + 4`.
- R4: With jump kind 2'b01 (register jump), `next_pc_o` equals `rs_val_i` bit for bit, with no alignment applied.
- R5: With jump kind 2'b10 (direct jump), `next_pc_o` is `{(pc_o+4)[31:28], target_i[25:0], 2'b00}`. The upper bits come from the incremented address, not from `pc_o`.
- R6: A register jump or a direct jump overrides a taken branch when both are requested in the same cycle.
- R7: Jump kind 2'b11 is reserved and behaves exactly like 2'b00, so a taken branch still applies.
- R8: `link_o` equals `pc_o + 4` for the whole cycle, and the value wraps from 32'hFFFF_FFFC to 32'h0000_0000.
- R9: On each rising edge with reset low, `pc_o` takes the value `next_pc_o` had just before that edge. `pc_o` does not change between edges.
- R10: Reset is synchronous and active high. `pc_o` becomes 32'h0000_0000 at the first rising edge with `rst` high, whatever the other inputs are, and it does not change before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imm_i | input | 16 | Signed word displacement for branches |
| target_i | input | 26 | Word index for direct jumps |
| rs_val_i | input | 32 | Register operand used as a register-jump address |
| branch_i | input | 1 | Current instruction is a conditional branch |
| zero_i | input | 1 | Comparison result is zero (branch condition met) |
| jump_kind_i | input | 2 | 00 none, 01 register jump, 10 direct jump, 11 reserved (as none) |
| pc_o | output | 32 | Current program counter |
| next_pc_o | output | 32 | Address to be loaded at the next edge |
| link_o | output | 32 | Return address (current PC plus four) |

## Verification
`next_pc_o` and `link_o` depend combinationally on `pc_o` and the inputs. They are due in the same cycle the stimulus is applied, so the bench drives just after a rising edge and reads them at the falling edge. `pc_o` is due one rising edge later, and the bench reads it just after that edge and compares it with the value `next_pc_o` was expected to hold. Reset is read both before its edge, where `pc_o` must be unchanged, and just after it, where it must be zero. Each vector first sets its starting PC through a register jump, so every case begins from a known address.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    // Jump kind encoding as seen on jump_kind_i
    typedef enum logic [1:0] {
        JK_NONE   = 2'b00,
        JK_REG    = 2'b01,
        JK_DIRECT = 2'b10,
        JK_RSVD   = 2'b11
    } jump_kind_e;

    // Source picked for the next program counter
    typedef enum logic [1:0] {
        SRC_SEQ    = 2'b00,
        SRC_BRANCH = 2'b01,
        SRC_REG    = 2'b10,
        SRC_DIRECT = 2'b11
    } pc_src_e;

endpackage

// File: rtl/pcseq_incr.sv
module pcseq_incr #(
    parameter int XLEN = 32,
    parameter int STEP = 4
) (
    input  logic [XLEN-1:0] pc_i,
    output logic [XLEN-1:0] seq_o
);
    localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

    always_comb begin
        seq_o = pc_i + STEP_V;
    end
endmodule

// File: rtl/pcseq_targets.sv
module pcseq_targets #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16,
    parameter int TGT_W = 26
) (
    input  logic [XLEN-1:0]  seq_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [TGT_W-1:0] target_i,
    output logic [XLEN-1:0]  branch_tgt_o,
    output logic [XLEN-1:0]  direct_tgt_o
);
    localparam int EXT_W = XLEN - IMM_W;
    localparam int HI_W  = XLEN - TGT_W - 2;

    logic [XLEN-1:0] disp_words;
    logic [XLEN-1:0] disp_bytes;

    always_comb begin
        disp_words   = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
        disp_bytes   = disp_words << 2;
        branch_tgt_o = seq_i + disp_bytes;
    end

    generate
        if (HI_W > 0) begin : g_region
            always_comb begin
                direct_tgt_o = {seq_i[XLEN-1 -: HI_W], target_i, 2'b00};
            end
        end else begin : g_flat
            always_comb begin
                direct_tgt_o = XLEN'({target_i, 2'b00});
            end
        end
    endgenerate
endmodule

// File: rtl/pcseq_select.sv
module pcseq_select
    import pcseq_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  jump_kind_e      jump_kind_i,
    input  logic            branch_i,
    input  logic            zero_i,
    input  logic [XLEN-1:0] seq_i,
    input  logic [XLEN-1:0] branch_tgt_i,
    input  logic [XLEN-1:0] rs_val_i,
    input  logic [XLEN-1:0] direct_tgt_i,
    output logic [XLEN-1:0] next_pc_o
);
    pc_src_e src;
    logic    taken;

    always_comb begin
        taken = branch_i & zero_i;
        unique case (jump_kind_i)
            JK_REG:          src = SRC_REG;
            JK_DIRECT:       src = SRC_DIRECT;
            JK_NONE, JK_RSVD: src = taken ? SRC_BRANCH : SRC_SEQ;
            default:         src = SRC_SEQ;
        endcase
    end

    always_comb begin
        unique case (src)
            SRC_SEQ:    next_pc_o = seq_i;
            SRC_BRANCH: next_pc_o = branch_tgt_i;
            SRC_REG:    next_pc_o = rs_val_i;
            SRC_DIRECT: next_pc_o = direct_tgt_i;
            default:    next_pc_o = seq_i;
        endcase
    end

    // R4
    reg_jump_chk: assert property (@(posedge clk) disable iff (rst)
        (jump_kind_i == JK_REG) |-> (next_pc_o == rs_val_i));

    // R3
    not_taken_chk: assert property (@(posedge clk) disable iff (rst)
        ((jump_kind_i == JK_NONE || jump_kind_i == JK_RSVD) && !zero_i)
            |-> (next_pc_o == seq_i));

    // R5
    direct_align_chk: assert property (@(posedge clk) disable iff (rst)
        (jump_kind_i == JK_DIRECT) |-> (next_pc_o[1:0] == 2'b00));
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              IMM_W    = 16,
    parameter int              TGT_W    = 26,
    parameter int              STEP     = 4,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [TGT_W-1:0] target_i,
    input  logic [XLEN-1:0]  rs_val_i,
    input  logic             branch_i,
    input  logic             zero_i,
    input  logic [1:0]       jump_kind_i,
    output logic [XLEN-1:0]  pc_o,
    output logic [XLEN-1:0]  next_pc_o,
    output logic [XLEN-1:0]  link_o
);
    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] seq;
    logic [XLEN-1:0] br_tgt;
    logic [XLEN-1:0] dir_tgt;
    logic [XLEN-1:0] nxt;

    pcseq_incr #(.XLEN(XLEN), .STEP(STEP)) u_incr (
        .pc_i  (pc_q),
        .seq_o (seq)
    );

    pcseq_targets #(.XLEN(XLEN), .IMM_W(IMM_W), .TGT_W(TGT_W)) u_targets (
        .seq_i        (seq),
        .imm_i        (imm_i),
        .target_i     (target_i),
        .branch_tgt_o (br_tgt),
        .direct_tgt_o (dir_tgt)
    );

    pcseq_select #(.XLEN(XLEN)) u_select (
        .clk          (clk),
        .rst          (rst),
        .jump_kind_i  (jump_kind_e'(jump_kind_i)),
        .branch_i     (branch_i),
        .zero_i       (zero_i),
        .seq_i        (seq),
        .branch_tgt_i (br_tgt),
        .rs_val_i     (rs_val_i),
        .direct_tgt_i (dir_tgt),
        .next_pc_o    (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) pc_q <= RESET_PC;
        else     pc_q <= nxt;
    end

    always_comb begin
        pc_o      = pc_q;
        next_pc_o = nxt;
        link_o    = seq;
    end

    // R10
    reset_pc_chk: assert property (@(posedge clk)
        rst |=> (pc_o == RESET_PC));

    // R9
    pc_load_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (pc_o == $past(next_pc_o)));
endmodule

// File: tb/pc_sequencer_tb.sv
module pc_sequencer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 13;

    typedef struct packed {
        logic [31:0] start;
        logic [15:0] imm;
        logic [25:0] tgt;
        logic [31:0] rs;
        logic        br;
        logic        zr;
        logic [1:0]  jk;
        logic [31:0] expect_nxt;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_1000, 16'h0000, 26'h0,       32'h0,          1'b0, 1'b0, 2'b00, 32'h0000_1004, 4'd1},
        '{32'h0000_1000, 16'h0010, 26'h0,       32'h0,          1'b1, 1'b1, 2'b00, 32'h0000_1044, 4'd2},
        '{32'h0000_1000, 16'hFFFF, 26'h0,       32'h0,          1'b1, 1'b1, 2'b00, 32'h0000_1000, 4'd2},
        '{32'h0000_1000, 16'h0010, 26'h0,       32'h0,          1'b1, 1'b0, 2'b00, 32'h0000_1004, 4'd3},
        '{32'h0000_2000, 16'h8000, 26'h0,       32'h0,          1'b1, 1'b1, 2'b00, 32'hFFFE_2004, 4'd2},
        '{32'h0040_0000, 16'h0000, 26'h0,       32'h1234_5679,  1'b0, 1'b0, 2'b01, 32'h1234_5679, 4'd4},
        '{32'h0FFF_FFFC, 16'h0000, 26'h1,       32'h0,          1'b0, 1'b0, 2'b10, 32'h1000_0004, 4'd5},
        '{32'hA000_0000, 16'h0000, 26'h3FFFFFF, 32'h0,          1'b0, 1'b0, 2'b10, 32'hAFFF_FFFC, 4'd5},
        '{32'h0000_1000, 16'h0010, 26'h0,       32'h0000_8000,  1'b1, 1'b1, 2'b01, 32'h0000_8000, 4'd6},
        '{32'h0000_3000, 16'h0010, 26'h400,     32'h0,          1'b1, 1'b1, 2'b10, 32'h0000_1000, 4'd6},
        '{32'h0000_1000, 16'h0010, 26'h0,       32'h0,          1'b0, 1'b1, 2'b11, 32'h0000_1004, 4'd7},
        '{32'h0000_1000, 16'h0010, 26'h0,       32'h0,          1'b1, 1'b1, 2'b11, 32'h0000_1044, 4'd7},
        '{32'hFFFF_FFFC, 16'h0000, 26'h0,       32'h0,          1'b0, 1'b0, 2'b00, 32'h0000_0000, 4'd8}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] imm_i = '0;
    logic [25:0] target_i = '0;
    logic [31:0] rs_val_i = '0;
    logic        branch_i = 1'b0;
    logic        zero_i = 1'b0;
    logic [1:0]  jump_kind_i = 2'b00;
    logic [31:0] pc_o, next_pc_o, link_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pc_sequencer u_dut (
        .clk(clk), .rst(rst), .imm_i(imm_i), .target_i(target_i),
        .rs_val_i(rs_val_i), .branch_i(branch_i), .zero_i(zero_i),
        .jump_kind_i(jump_kind_i), .pc_o(pc_o), .next_pc_o(next_pc_o),
        .link_o(link_o)
    );

    function automatic string req_name(input logic [3:0] r);
        case (r)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            4'd9: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic load_pc(input logic [31:0] addr);
        jump_kind_i = 2'b01;
        rs_val_i    = addr;
        branch_i    = 1'b0;
        zero_i      = 1'b0;
        tick();
    endtask

    initial begin
        // Reset state (R10): two edges with reset high
        tick();
        tick();
        check("R10", "pc after reset", pc_o, 32'h0);
        check("R8", "link after reset", link_o, 32'h4);
        check("R1", "next after reset", next_pc_o, 32'h4);
        rst = 1'b0;

        // Vector table: R1..R8 and R9 register update
        for (int i = 0; i < NVEC; i++) begin
            load_pc(VECS[i].start);
            check("R9", "pc preload", pc_o, VECS[i].start);
            imm_i       = VECS[i].imm;
            target_i    = VECS[i].tgt;
            rs_val_i    = VECS[i].rs;
            branch_i    = VECS[i].br;
            zero_i      = VECS[i].zr;
            jump_kind_i = VECS[i].jk;
            @(negedge clk);
            check(req_name(VECS[i].req), "next pc", next_pc_o, VECS[i].expect_nxt);
            check("R8", "link value", link_o, VECS[i].start + 32'd4);
            tick();
            check("R9", "pc after edge", pc_o, VECS[i].expect_nxt);
        end

        // R9: pc holds between edges while inputs change
        load_pc(32'h0000_7000);
        jump_kind_i = 2'b01;
        rs_val_i    = 32'h0000_9000;
        #2;
        rs_val_i    = 32'h0000_A000;
        @(negedge clk);
        check("R9", "pc stable mid-cycle", pc_o, 32'h0000_7000);
        tick();
        check("R9", "pc takes last next", pc_o, 32'h0000_A000);

        // R10: synchronous reset overrides an active jump
        load_pc(32'h0000_5000);
        rst         = 1'b1;
        jump_kind_i = 2'b01;
        rs_val_i    = 32'h0000_9999;
        @(negedge clk);
        check("R10", "pc before reset edge", pc_o, 32'h0000_5000);
        tick();
        check("R10", "pc at reset edge", pc_o, 32'h0);
        rst         = 1'b0;
        jump_kind_i = 2'b00;
        tick();
        check("R1", "sequential after reset", pc_o, 32'h4);

        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule